// File: doc/BRIEF.md
# PWM Emergency Shutdown Controller

This block gathers the fault sources of a motor-control stage and raises a brake request that drives the PWM outputs to their safe state. Four fault categories are latched into sticky flags: the external brake pin, a same-level short on any of three complementary phase pairs, any of three analog comparator trips, and oscillator failure. A software brake bit adds to the request for as long as it is set. It is not latched.

The external pin has a selectable active level. It can also pass through a noise filter. The filter samples the pin on ticks of a prescaler and only takes a new level once that level has been seen on three ticks in a row. Software programs enables, polarity, filter setup and per-category interrupt enables through a small synchronous write port and a combinational read port. A latched flag is released only by writing a one to its clear bit. The pin is expected to come in already synchronized to `clk`.

Top module: `pfb_brake_ctrl`

## Requirements
- R1: After synchronous reset, all registers and flags are zero, `brake_req` and `irq` are low, and every register reads back the value last written to it. Map: address 0 is control, 1 is pair level select (bits 2:0), 2 is interrupt enable (bits 3:0), 3 reads status and a write to it is a clear mask.
- R2: Control register bits: 0 enables the port brake, 3:1 enable comparators 0..2, 4 enables the oscillator brake, 7:5 enable pairs 0..2, 9:8 select the filter divider, 10 enables the filter, 11 selects active-low port polarity, 12 is the software brake. A flag sets on the clock edge at which its enabled source is active. A disabled source sets nothing.
- R3: Flags are sticky. Writing address 3 with bit k set clears flag k (0 port, 1 short, 2 comparator, 3 oscillator), unless that flag's source is active on the same edge.
- R4: `brake_req` is high exactly when the software brake bit is set or any flag is set.
- R5: `irq` is high exactly when some flag k is set while interrupt enable bit k is set.
- R6: The port source is the selected pin level XOR the active-low bit. With the bit at 0 a high pin is active. With the bit at 1 a low pin is active.
- R7: With the filter enabled, the pin level used is the last level sampled identically on three consecutive prescaler ticks. A tick occurs every 1, 8, 32 or 128 clocks for divider codes 0, 1, 2 and 3. Shorter pulses are rejected.
- R8: Pair i is shorted when high and low are both 1 with level-select bit i set, or both 0 with it clear. The short brake fires only for enabled pairs.
- R9: The comparator category fires on any trip whose enable is set. The oscillator category fires on the fail input while its enable is set.
- R10: Status bits 3:0 are the flags. Bit 4 is the live port state, independent of the port enable. Bit 5 is the live OR of the short conditions of all pairs, independent of the pair enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 13 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 13 | Read data, combinational |
| brake_pin | input | 1 | External brake pin (synchronized) |
| cmp_trip | input | 3 | Comparator trip inputs |
| osc_fail | input | 1 | Oscillator failure input |
| pwm_hi | input | 3 | High-side PWM levels, one per pair |
| pwm_lo | input | 3 | Low-side PWM levels, one per pair |
| brake_req | output | 1 | Brake request to the PWM outputs |
| irq | output | 1 | Interrupt request |

## Verification
Each category is driven first with its enable off and then with it on, which separates a gated source from an ungated one. A clear is written while the source is still asserted and again after it has dropped, which separates the priority of a set over a clear from a plain sticky latch. The pin is driven with pulses shorter and longer than three prescaler ticks at divider codes 0, 1 and 3, and both polarities are exercised, so a wrong divider, a wrong filter depth or an inverted polarity each shows up. Pairs are driven both-high and both-low under both level selects and with the enables masked, to confirm that the short detection and its gating are separate.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
    parameter int NUM_CMP    = 3;
    parameter int NUM_PAIR   = 3;
    parameter int NUM_CAT    = 4;
    parameter int FILT_DEPTH = 3;
    parameter int MAX_DIV    = 128;
    localparam int PRE_W     = $clog2(MAX_DIV);

    localparam int CAT_PORT  = 0;
    localparam int CAT_SHORT = 1;
    localparam int CAT_CMP   = 2;
    localparam int CAT_OSC   = 3;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_LEVEL = 2'd1;
    localparam logic [1:0] ADDR_IRQEN = 2'd2;
    localparam logic [1:0] ADDR_STAT  = 2'd3;

    typedef struct packed {
        logic                sw_brake;
        logic                act_low;
        logic                flt_en;
        logic [1:0]          flt_div;
        logic [NUM_PAIR-1:0] pair_en;
        logic                osc_en;
        logic [NUM_CMP-1:0]  cmp_en;
        logic                port_en;
    } ctrl_t;

    localparam int REG_W = $bits(ctrl_t);

    function automatic logic [PRE_W-1:0] div_limit(input logic [1:0] code);
        case (code)
            2'd0:    return '0;
            2'd1:    return PRE_W'(MAX_DIV / 16 - 1);
            2'd2:    return PRE_W'(MAX_DIV / 4 - 1);
            default: return PRE_W'(MAX_DIV - 1);
        endcase
    endfunction
endpackage

// File: rtl/pfb_pin_filter.sv
module pfb_pin_filter
    import pfb_pkg::*;
#(
    parameter int DEPTH = FILT_DEPTH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] div_code,
    input  logic       pin_raw,
    output logic       pin_filt,
    output logic       tick
);
    logic [PRE_W-1:0] cnt;
    logic [DEPTH-2:0] hist;
    logic [DEPTH-1:0] nxt;

    assign tick = (cnt >= div_limit(div_code));
    assign nxt  = {hist, pin_raw};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            hist     <= '0;
            pin_filt <= 1'b0;
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick) begin
                hist <= nxt[DEPTH-2:0];
                if (&nxt)
                    pin_filt <= 1'b1;
                else if (~|nxt)
                    pin_filt <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pfb_short_detect.sv
module pfb_short_detect
    import pfb_pkg::*;
#(
    parameter int N = NUM_PAIR
) (
    input  logic [N-1:0] hi,
    input  logic [N-1:0] lo,
    input  logic [N-1:0] hi_sel,
    output logic [N-1:0] shorted
);
    for (genvar i = 0; i < N; i++) begin : g_pair
        always_comb begin
            if (hi_sel[i])
                shorted[i] = hi[i] & lo[i];
            else
                shorted[i] = ~hi[i] & ~lo[i];
        end
    end
endmodule

// File: rtl/pfb_flag_bank.sv
module pfb_flag_bank
    import pfb_pkg::*;
#(
    parameter int N = NUM_CAT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar k = 0; k < N; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[k] <= 1'b0;
            else if (src[k])
                flags[k] <= 1'b1;
            else if (clr[k])
                flags[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/pfb_brake_ctrl.sv
module pfb_brake_ctrl
    import pfb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    input  logic [1:0]          rd_addr,
    output logic [REG_W-1:0]    rd_data,
    input  logic                brake_pin,
    input  logic [NUM_CMP-1:0]  cmp_trip,
    input  logic                osc_fail,
    input  logic [NUM_PAIR-1:0] pwm_hi,
    input  logic [NUM_PAIR-1:0] pwm_lo,
    output logic                brake_req,
    output logic                irq
);
    ctrl_t               ctrl;
    logic [NUM_PAIR-1:0] lvl_sel;
    logic [NUM_CAT-1:0]  irq_en;
    logic [NUM_CAT-1:0]  src;
    logic [NUM_CAT-1:0]  clr;
    logic [NUM_CAT-1:0]  flags;
    logic [NUM_PAIR-1:0] short_vec;
    logic                filt;
    logic                flt_tick;
    logic                port_state;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            lvl_sel <= '0;
            irq_en  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL:  ctrl    <= ctrl_t'(wr_data);
                ADDR_LEVEL: lvl_sel <= wr_data[NUM_PAIR-1:0];
                ADDR_IRQEN: irq_en  <= wr_data[NUM_CAT-1:0];
                default:    ;
            endcase
        end
    end

    assign clr = (wr_en && wr_addr == ADDR_STAT) ? wr_data[NUM_CAT-1:0] : '0;

    pfb_pin_filter #(.DEPTH(FILT_DEPTH)) u_filt (
        .clk      (clk),
        .rst      (rst),
        .div_code (ctrl.flt_div),
        .pin_raw  (brake_pin),
        .pin_filt (filt),
        .tick     (flt_tick)
    );

    pfb_short_detect #(.N(NUM_PAIR)) u_short (
        .hi      (pwm_hi),
        .lo      (pwm_lo),
        .hi_sel  (lvl_sel),
        .shorted (short_vec)
    );

    assign port_state = (ctrl.flt_en ? filt : brake_pin) ^ ctrl.act_low;

    always_comb begin
        src            = '0;
        src[CAT_PORT]  = ctrl.port_en & port_state;
        src[CAT_SHORT] = |(short_vec & ctrl.pair_en);
        src[CAT_CMP]   = |(cmp_trip & ctrl.cmp_en);
        src[CAT_OSC]   = ctrl.osc_en & osc_fail;
    end

    pfb_flag_bank #(.N(NUM_CAT)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .src   (src),
        .clr   (clr),
        .flags (flags)
    );

    assign brake_req = ctrl.sw_brake | (|flags);
    assign irq       = |(flags & irq_en);

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CTRL:  rd_data = REG_W'(ctrl);
            ADDR_LEVEL: rd_data[NUM_PAIR-1:0] = lvl_sel;
            ADDR_IRQEN: rd_data[NUM_CAT-1:0]  = irq_en;
            default: begin
                rd_data[NUM_CAT-1:0] = flags;
                rd_data[NUM_CAT]     = port_state;
                rd_data[NUM_CAT+1]   = |short_vec;
            end
        endcase
    end
endmodule

module pfb_brake_checker
    import pfb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NUM_CAT-1:0] src,
    input logic [NUM_CAT-1:0] clr,
    input logic [NUM_CAT-1:0] flags,
    input logic [NUM_CAT-1:0] irq_en,
    input logic               sw_brake,
    input logic               brake_req,
    input logic               irq,
    input logic               filt,
    input logic               flt_tick
);
    for (genvar k = 0; k < NUM_CAT; k++) begin : g_chk
        assert_flag_set_R2: assert property (@(posedge clk) disable iff (rst)
            src[k] |=> flags[k]);
        assert_flag_cause_R2: assert property (@(posedge clk) disable iff (rst)
            $rose(flags[k]) |-> $past(src[k]));
        assert_flag_hold_R3: assert property (@(posedge clk) disable iff (rst)
            (flags[k] && !clr[k]) |=> flags[k]);
        assert_flag_clear_R3: assert property (@(posedge clk) disable iff (rst)
            (clr[k] && !src[k]) |=> !flags[k]);
    end

    assert_brake_on_R4: assert property (@(posedge clk) disable iff (rst)
        (sw_brake || (|flags)) |-> brake_req);
    assert_brake_off_R4: assert property (@(posedge clk) disable iff (rst)
        brake_req |-> (sw_brake || (|flags)));
    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|(flags & irq_en)));
    assert_irq_seen_R5: assert property (@(posedge clk) disable iff (rst)
        (|(flags & irq_en)) |-> irq);
    assert_filt_tick_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt) |-> $past(flt_tick));
endmodule

bind pfb_brake_ctrl pfb_brake_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .src       (src),
    .clr       (clr),
    .flags     (flags),
    .irq_en    (irq_en),
    .sw_brake  (ctrl.sw_brake),
    .brake_req (brake_req),
    .irq       (irq),
    .filt      (filt),
    .flt_tick  (flt_tick)
);

// File: tb/tb_pfb_brake_ctrl.sv
module tb_pfb_brake_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [12:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd3;
    logic [12:0] rd_data;
    logic        brake_pin = 1'b0;
    logic [2:0]  cmp_trip = '0;
    logic        osc_fail = 1'b0;
    logic [2:0]  pwm_hi = 3'b111;
    logic [2:0]  pwm_lo = 3'b000;
    logic        brake_req;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    pfb_brake_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .brake_pin(brake_pin),
        .cmp_trip(cmp_trip), .osc_fail(osc_fail), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .brake_req(brake_req), .irq(irq)
    );

    // behavioural reference model
    logic [12:0] m_ctrl;
    logic [2:0]  m_lvl;
    logic [3:0]  m_ien;
    logic [3:0]  m_flags;
    int          m_cnt;
    bit          m_hist[$];
    logic        m_filt;

    function automatic logic m_port();
        logic lv;
        lv = m_ctrl[10] ? m_filt : brake_pin;
        return lv ^ m_ctrl[11];
    endfunction

    function automatic logic [2:0] m_short();
        logic [2:0] s;
        for (int i = 0; i < 3; i++)
            s[i] = m_lvl[i] ? (pwm_hi[i] && pwm_lo[i]) : (!pwm_hi[i] && !pwm_lo[i]);
        return s;
    endfunction

    function automatic logic [12:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_ctrl;
            2'd1: return {10'd0, m_lvl};
            2'd2: return {9'd0, m_ien};
            default: return {7'd0, |m_short(), m_port(), m_flags};
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = '0; m_lvl = '0; m_ien = '0; m_flags = '0;
            m_cnt = 0; m_filt = 0;
            m_hist.delete(); m_hist.push_back(0); m_hist.push_back(0);
        end else begin
            logic [3:0] src, clr;
            int lim;
            src[0] = m_ctrl[0] && m_port();
            src[1] = |(m_short() & m_ctrl[7:5]);
            src[2] = |(cmp_trip & m_ctrl[3:1]);
            src[3] = m_ctrl[4] && osc_fail;
            clr = (wr_en && wr_addr == 2'd3) ? wr_data[3:0] : 4'd0;
            m_flags = (m_flags & ~clr) | src;
            case (m_ctrl[9:8])
                2'd0: lim = 1;
                2'd1: lim = 8;
                2'd2: lim = 32;
                default: lim = 128;
            endcase
            if (m_cnt >= lim - 1) begin
                m_cnt = 0;
                if (m_hist[0] == brake_pin && m_hist[1] == brake_pin)
                    m_filt = brake_pin;
                m_hist.push_back(brake_pin);
                void'(m_hist.pop_front());
            end else begin
                m_cnt++;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_ctrl = wr_data;
                    2'd1: m_lvl  = wr_data[2:0];
                    2'd2: m_ien  = wr_data[3:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string req, input string what, input logic [12:0] got, input logic [12:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(cur_req, "brake_req", {12'd0, brake_req}, {12'd0, m_ctrl[12] | (|m_flags)});
            check(cur_req, "irq", {12'd0, irq}, {12'd0, |(m_flags & m_ien)});
            check(cur_req, "rd_data", rd_data, m_read(rd_addr));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [12:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1: reset state
        cur_req = "R1";
        check("R1", "reset brake", {12'd0, brake_req}, 13'd0);
        check("R1", "reset irq", {12'd0, irq}, 13'd0);
        check("R1", "reset status", rd_data, 13'd0);
        wr(2'd0, 13'h0010);
        rd_addr = 2'd0; #1;
        check("R1", "ctrl readback", rd_data, 13'h0010);
        rd_addr = 2'd3;
        wr(2'd0, 13'h0000);

        // R9/R2: disabled then enabled oscillator source
        cur_req = "R9";
        osc_fail = 1'b1; step(2); osc_fail = 1'b0; step(1);
        check("R2", "disabled osc no flag", rd_data & 13'hF, 13'h0);
        wr(2'd0, 13'h0010);
        osc_fail = 1'b1; step(1); osc_fail = 1'b0;
        check("R9", "osc flag", rd_data & 13'hF, 13'h8);
        check("R4", "brake from flag", {12'd0, brake_req}, 13'd1);

        // R3: sticky, clear, clear ignored while source active
        cur_req = "R3";
        step(5);
        check("R3", "flag sticky", rd_data & 13'hF, 13'h8);
        wr(2'd3, 13'h0008);
        check("R3", "flag cleared", rd_data & 13'hF, 13'h0);
        osc_fail = 1'b1;
        wr(2'd3, 13'h0008);
        check("R3", "clear vs active source", rd_data & 13'hF, 13'h8);
        osc_fail = 1'b0;

        // R5: interrupt enables
        cur_req = "R5";
        wr(2'd2, 13'h0008); step(1);
        check("R5", "irq enabled", {12'd0, irq}, 13'd1);
        wr(2'd2, 13'h0004); step(1);
        check("R5", "irq masked", {12'd0, irq}, 13'd0);
        wr(2'd3, 13'h000F);

        // R9: comparator enables
        cur_req = "R9";
        wr(2'd0, 13'h0004);
        cmp_trip = 3'b001; step(2); cmp_trip = 3'b000; step(1);
        check("R9", "masked cmp", rd_data & 13'hF, 13'h0);
        cmp_trip = 3'b010; step(1); cmp_trip = 3'b000; step(1);
        check("R9", "enabled cmp", rd_data & 13'hF, 13'h4);
        check("R5", "cmp irq", {12'd0, irq}, 13'd1);
        wr(2'd3, 13'h000F);

        // R8/R10: short detection
        cur_req = "R8";
        wr(2'd1, 13'h0002);
        wr(2'd0, 13'h00C0);
        pwm_hi = 3'b111; pwm_lo = 3'b010; step(1);
        check("R10", "live short", rd_data & 13'h20, 13'h20);
        check("R8", "pair1 high short", rd_data & 13'hF, 13'h2);
        pwm_lo = 3'b000; wr(2'd3, 13'h0002); step(1);
        check("R8", "cleared", rd_data & 13'hF, 13'h0);
        pwm_hi = 3'b110; step(2);
        check("R8", "pair0 low short disabled", rd_data & 13'h2F, 13'h20);
        wr(2'd0, 13'h00E0); step(1);
        check("R8", "pair0 low short enabled", rd_data & 13'hF, 13'h2);
        pwm_hi = 3'b111; wr(2'd3, 13'h000F); wr(2'd0, 13'h0000);

        // R6/R10: polarity and live state
        cur_req = "R6";
        brake_pin = 1'b1; step(2);
        check("R10", "live port disabled", rd_data & 13'h1F, 13'h10);
        brake_pin = 1'b0;
        wr(2'd0, 13'h0001);
        step(2);
        check("R6", "active high idle", rd_data & 13'hF, 13'h0);
        brake_pin = 1'b1; step(1); brake_pin = 1'b0; step(1);
        check("R6", "active high hit", rd_data & 13'hF, 13'h1);
        brake_pin = 1'b1;
        wr(2'd0, 13'h0801);
        wr(2'd3, 13'h0001); step(1);
        check("R6", "active low idle", rd_data & 13'hF, 13'h0);
        brake_pin = 1'b0; step(1);
        check("R6", "active low hit", rd_data & 13'hF, 13'h1);

        // R7: filter, divider codes 0, 1 and 3
        cur_req = "R7";
        wr(2'd0, 13'h0000); step(10);
        wr(2'd3, 13'h000F);
        wr(2'd0, 13'h0401);
        brake_pin = 1'b1; step(2); brake_pin = 1'b0; step(6);
        check("R7", "div1 short pulse", rd_data & 13'hF, 13'h0);
        brake_pin = 1'b1; step(3); brake_pin = 1'b0; step(6);
        check("R7", "div1 three samples", rd_data & 13'hF, 13'h1);
        step(6); wr(2'd3, 13'h000F);
        wr(2'd0, 13'h0501);
        brake_pin = 1'b1; step(10); brake_pin = 1'b0; step(40);
        check("R7", "div8 glitch", rd_data & 13'hF, 13'h0);
        brake_pin = 1'b1; step(40);
        check("R7", "div8 steady", rd_data & 13'hF, 13'h1);
        brake_pin = 1'b0; step(40); wr(2'd3, 13'h000F);
        wr(2'd0, 13'h0701);
        brake_pin = 1'b1; step(200); brake_pin = 1'b0; step(500);
        check("R7", "div128 glitch", rd_data & 13'hF, 13'h0);
        brake_pin = 1'b1; step(500);
        check("R7", "div128 steady", rd_data & 13'hF, 13'h1);
        brake_pin = 1'b0; step(500); wr(2'd3, 13'h000F);

        // R4: software brake
        cur_req = "R4";
        wr(2'd0, 13'h1000); step(1);
        check("R4", "sw brake on", {12'd0, brake_req}, 13'd1);
        check("R4", "sw brake no flag", rd_data & 13'hF, 13'h0);
        wr(2'd0, 13'h0000); step(1);
        check("R4", "sw brake off", {12'd0, brake_req}, 13'd0);

        step(2);
        finish_run();
    end
endmodule